// File: doc/BRIEF.md
# Packed Single-to-Double Widening Unit

This unit takes up to four packed IEEE-754 single-precision values and widens each to double precision. One request enters per cycle through `op_valid`. The unit computes the converted lanes combinationally and registers them into a 256-bit result one clock edge later. A two-bit form selector picks one of three encodings. The legacy 128-bit form converts the two low lanes and keeps the upper half of the old destination. The vector-extension 128-bit form converts two lanes and clears the upper half. The vector-extension 256-bit form converts all four lanes.

The vector-extension forms carry a 4-bit reserved register-specifier field that must be all ones. When this check fails, or when the unused selector code arrives, the unit raises an undefined-opcode flag and passes the old destination value back unchanged. A caller that owns the register file can then write the result back without any special case. The unit also reports two exception flags, invalid and denormal-operand, each ORed over the lanes that take part in the operation.

Top module: `sp2dp_widen`

## Requirements
- R1: Source bits [31:0] produce result bits [63:0] and source bits [63:32] produce result bits [127:64] in every form that executes.
- R2: With form code 2'b10 (vector 256-bit), source bits [95:64] also produce result bits [191:128] and source bits [127:96] produce result bits [255:192].
- R3: With form code 2'b00 (legacy 128-bit), result bits [255:128] equal the prior-destination bits [255:128], and the specifier field is ignored.
- R4: With form code 2'b01 (vector 128-bit) and a valid specifier, result bits [255:128] are zero.
- R5: With form code 2'b01 or 2'b10 and a specifier other than 4'b1111, `ud_flag` is 1, the result equals the prior destination, and both exception flags are 0.
- R6: Form code 2'b11 is undefined: `ud_flag` is 1, the result equals the prior destination, and both exception flags are 0.
- R7: A normal single (exponent 1..254) widens exactly: sign copied, exponent plus 896, fraction placed in the top 23 of the 52 fraction bits with zeros below.
- R8: A subnormal single (exponent 0, fraction nonzero) becomes the exact normalized double, and it sets `den_flag`.
- R9: Zeros and infinities keep their sign and become the double zero (exponent 0) or infinity (exponent 2047, fraction 0) encoding, with no flag raised.
- R10: A NaN keeps its sign and its payload shifted up 29 bits and has fraction bit 51 set. A signalling NaN (single fraction bit 22 clear) sets `inv_flag`, and a quiet NaN sets no flag.
- R11: The exception flags are the OR over active lanes only. Lanes 2 and 3 in the 128-bit forms raise no flag.
- R12: After reset, `res_valid`, `result` and the flags are 0. The outputs update on the edge that samples `op_valid` high, `res_valid` is 1 for exactly that following cycle, and the outputs hold while `op_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Request strobe, one operation per cycle |
| form | input | 2 | 00 legacy 128-bit, 01 vector 128-bit, 10 vector 256-bit, 11 undefined |
| spec | input | 4 | Reserved register-specifier field |
| src | input | 128 | Packed single-precision source lanes |
| dest_prior | input | 256 | Prior value of the destination register |
| res_valid | output | 1 | Result strobe, one cycle after `op_valid` |
| result | output | 256 | Destination value to write back |
| ud_flag | output | 1 | Undefined-opcode indication |
| inv_flag | output | 1 | Invalid-operation exception flag |
| den_flag | output | 1 | Denormal-operand exception flag |

## Verification
The clocked assertions assume that `form`, `spec` and `dest_prior` are stable and known at the edge where `op_valid` is high. The immediate lane assertions assume that a source lane never holds unknown bits while it is being converted. The stimulus drives every input at the falling edge and keeps it fixed through the sampling edge, and it always supplies fully defined source and prior-destination words. The sweep covers all 256 exponent values with boundary fractions in every lane, every specifier value in each form, and signalling NaNs placed in both active and inactive lanes.

// File: rtl/sp2dp_pkg.sv
// Shared widths, biases and form encoding for the widening unit.
// Assumes IEEE-754 binary32 input and binary64 output layouts.
package sp2dp_pkg;
    localparam int SP_W      = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int SP_BIAS   = 127;
    localparam int DP_W      = 64;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int DP_BIAS   = 1023;
    // Exponent shift for normal values and subnormal base offset
    localparam int REBIAS    = DP_BIAS - SP_BIAS;
    localparam int DEN_OFF   = DP_BIAS - SP_BIAS + 1 - SP_FRAC_W;
    localparam int PAD_W     = DP_FRAC_W - SP_FRAC_W;

    typedef enum logic [1:0] {
        FORM_LEG128 = 2'b00,
        FORM_VEC128 = 2'b01,
        FORM_VEC256 = 2'b10,
        FORM_BAD    = 2'b11
    } form_e;
endpackage

// File: rtl/sp2dp_lead_one.sv
// Finds the bit position of the most significant set bit of a vector.
// Assumes the caller only uses the position when the input is nonzero.
module sp2dp_lead_one #(
    parameter int W   = 23,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [PW-1:0] pos
);
    // Scan upward so the highest set bit wins
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = PW'(i);
        end
    end
endmodule

// File: rtl/sp2dp_lane.sv
// Widens one binary32 value to binary64 and reports its exception flags.
// Assumes a defined input; the conversion is exact for every input class.
module sp2dp_lane
    import sp2dp_pkg::*;
(
    input  logic [SP_W-1:0] sp_in,
    output logic [DP_W-1:0] dp_out,
    output logic            inv_o,
    output logic            den_o
);
    localparam int PW = $clog2(SP_FRAC_W);

    logic                 sgn;
    logic [SP_EXP_W-1:0]  exp_in;
    logic [SP_FRAC_W-1:0] frac_in;
    logic [PW-1:0]        lead;
    logic [DP_EXP_W-1:0]  exp_out;
    logic [DP_FRAC_W-1:0] frac_out;
    logic [DP_FRAC_W-1:0] den_frac;

    assign sgn     = sp_in[SP_W-1];
    assign exp_in  = sp_in[SP_W-2 -: SP_EXP_W];
    assign frac_in = sp_in[SP_FRAC_W-1:0];

    sp2dp_lead_one #(.W(SP_FRAC_W)) i_lead (
        .vec (frac_in),
        .pos (lead)
    );

    // Subnormal fraction: shift the leading one out past bit 51
    assign den_frac = {{PAD_W{1'b0}}, frac_in} << (6'(DP_FRAC_W) - 6'(lead));

    // Classify the input and build exponent, fraction and flags
    always_comb begin
        inv_o    = 1'b0;
        den_o    = 1'b0;
        exp_out  = DP_EXP_W'(exp_in) + DP_EXP_W'(REBIAS);
        frac_out = {frac_in, {PAD_W{1'b0}}};
        if (exp_in == '1) begin
            exp_out = '1;
            if (frac_in != '0) begin
                frac_out[DP_FRAC_W-1] = 1'b1;
                inv_o = ~frac_in[SP_FRAC_W-1];
            end
        end else if (exp_in == '0) begin
            if (frac_in == '0) begin
                exp_out = '0;
            end else begin
                exp_out  = DP_EXP_W'(lead) + DP_EXP_W'(DEN_OFF);
                frac_out = den_frac;
                den_o    = 1'b1;
            end
        end
    end

    assign dp_out = {sgn, exp_out, frac_out};

    // A subnormal input must yield a normal double below the normal range
    always_comb begin
        if (den_o) begin
            AST_DEN_NORMAL: assert (dp_out[DP_W-2 -: DP_EXP_W] != '0 &&
                dp_out[DP_W-2 -: DP_EXP_W] < DP_EXP_W'(REBIAS + 1)); // R8
        end
        if (inv_o) begin
            AST_INV_QUIET: assert (dp_out[DP_FRAC_W-1] &&
                dp_out[DP_W-2 -: DP_EXP_W] == '1); // R10
        end
    end
endmodule

// File: rtl/sp2dp_widen.sv
// Packed single-to-double widening unit with one register stage.
// Assumes form, spec, src and dest_prior are valid when op_valid is high;
// the result is the complete destination value to write back.
module sp2dp_widen
    import sp2dp_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int NARROW = 2,
    localparam int SRC_W = LANES * SP_W,
    localparam int DST_W = LANES * DP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       form,
    input  logic [3:0]       spec,
    input  logic [SRC_W-1:0] src,
    input  logic [DST_W-1:0] dest_prior,
    output logic             res_valid,
    output logic [DST_W-1:0] result,
    output logic             ud_flag,
    output logic             inv_flag,
    output logic             den_flag
);
    form_e            form_q;
    logic             bad_op;
    logic [LANES-1:0] lane_on;
    logic [LANES-1:0] lane_inv;
    logic [LANES-1:0] lane_den;
    logic [DST_W-1:0] next_res;

    assign form_q = form_e'(form);

    // Reserved specifier must be all ones in the vector forms
    assign bad_op = (form_q == FORM_BAD) ||
                    (form_q != FORM_LEG128 && spec != 4'b1111);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DP_W-1:0] dp;

        sp2dp_lane i_lane (
            .sp_in  (src[g*SP_W +: SP_W]),
            .dp_out (dp),
            .inv_o  (lane_inv[g]),
            .den_o  (lane_den[g])
        );

        if (g < NARROW) begin : g_low
            assign lane_on[g] = 1'b1;
        end else begin : g_high
            assign lane_on[g] = (form_q == FORM_VEC256);
        end

        // Pick converted, preserved or cleared data for this lane
        always_comb begin
            if (bad_op)
                next_res[g*DP_W +: DP_W] = dest_prior[g*DP_W +: DP_W];
            else if (lane_on[g])
                next_res[g*DP_W +: DP_W] = dp;
            else if (form_q == FORM_LEG128)
                next_res[g*DP_W +: DP_W] = dest_prior[g*DP_W +: DP_W];
            else
                next_res[g*DP_W +: DP_W] = '0;
        end
    end

    // Register the result and flags on each accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            result    <= '0;
            ud_flag   <= 1'b0;
            inv_flag  <= 1'b0;
            den_flag  <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                result   <= next_res;
                ud_flag  <= bad_op;
                inv_flag <= !bad_op && |(lane_inv & lane_on);
                den_flag <= !bad_op && |(lane_den & lane_on);
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid); // R12
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid && $stable(result)); // R12
    AST_LEG_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && form == FORM_LEG128 |=>
        result[DST_W-1:NARROW*DP_W] == $past(dest_prior[DST_W-1:NARROW*DP_W])); // R3
    AST_VEC128_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && form == FORM_VEC128 && spec == 4'b1111 |=>
        result[DST_W-1:NARROW*DP_W] == '0); // R4
    AST_UD_KEEPS_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && form != FORM_LEG128 && spec != 4'b1111 |=>
        ud_flag && result == $past(dest_prior)); // R5
    AST_UD_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ud_flag |-> !inv_flag && !den_flag); // R6
endmodule

// File: tb/test_sp2dp_widen.sv
`timescale 1ns/1ps
module test_sp2dp_widen;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [1:0]   form = 2'b00;
    logic [3:0]   spec = 4'hF;
    logic [127:0] src = '0;
    logic [255:0] dest_prior = '0;
    logic         res_valid;
    logic [255:0] result;
    logic         ud_flag, inv_flag, den_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    sp2dp_widen i_sp2dp_widen (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .form(form),
        .spec(spec), .src(src), .dest_prior(dest_prior),
        .res_valid(res_valid), .result(result), .ud_flag(ud_flag),
        .inv_flag(inv_flag), .den_flag(den_flag)
    );

    // Arithmetic reference: returns {inv, den, double}
    function automatic logic [65:0] ref_conv(input logic [31:0] x);
        logic [23:0] m;
        int ex;
        logic [10:0] e;
        logic [51:0] f;
        logic inv, den;
        inv = 0; den = 0;
        if (x[30:23] == 8'hFF) begin
            e = 11'h7FF;
            f = {x[22:0], 29'd0};
            if (x[22:0] != 0) begin
                f[51] = 1'b1;
                inv = !x[22];
            end
        end else if (x[30:23] == 0) begin
            if (x[22:0] == 0) begin
                e = 0; f = 0;
            end else begin
                den = 1;
                m = {1'b0, x[22:0]};
                ex = -126;
                for (int k = 0; k < 24; k++) begin
                    if (!m[23]) begin
                        m = m << 1;
                        ex = ex - 1;
                    end
                end
                e = 11'(ex + 1023);
                f = {m[22:0], 29'd0};
            end
        end else begin
            e = 11'(int'(x[30:23]) - 127 + 1023);
            f = {x[22:0], 29'd0};
        end
        return {inv, den, x[31], e, f};
    endfunction

    task automatic check(input string req, input logic [258:0] act,
                         input logic [258:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request, then compare the registered outputs
    task automatic run_op(input string req, input logic [1:0] f,
                          input logic [3:0] s, input logic [127:0] sv,
                          input logic [255:0] pv);
        logic [255:0] er;
        logic ei, ed, eu;
        logic [65:0] c;
        er = '0; ei = 0; ed = 0;
        eu = (f == 2'b11) || (f != 2'b00 && s != 4'hF);
        for (int i = 0; i < 4; i++) begin
            if (i < 2 || f == 2'b10) begin
                c = ref_conv(sv[i*32 +: 32]);
                er[i*64 +: 64] = c[63:0];
                ei |= c[65];
                ed |= c[64];
            end else if (f == 2'b00) begin
                er[i*64 +: 64] = pv[i*64 +: 64];
            end
        end
        if (eu) begin
            er = pv; ei = 0; ed = 0;
        end
        @(negedge clk);
        op_valid = 1; form = f; spec = s; src = sv; dest_prior = pv;
        @(negedge clk);
        op_valid = 0;
        check(req, {res_valid, ud_flag, inv_flag, den_flag, result[254:0]},
              {1'b1, eu, ei, ed, er[254:0]});
        check(req, {255'd0, result[255], 3'd0}, {255'd0, er[255], 3'd0});
    endtask

    function automatic logic [31:0] mk(input logic s, input logic [7:0] e,
                                       input logic [22:0] f);
        return {s, e, f};
    endfunction

    initial begin
        logic [22:0] fr [6];
        logic [255:0] pr;
        logic [127:0] sv;
        logic [255:0] held;
        fr[0] = 23'h000000; fr[1] = 23'h000001; fr[2] = 23'h400000;
        fr[3] = 23'h3FFFFF; fr[4] = 23'h2AAAAA; fr[5] = 23'h7FFFFF;
        pr = {8{32'hA5C3_1E7D}};
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", {res_valid, ud_flag, inv_flag, den_flag, result[254:0]}, '0);
        rst_n = 1;
        // R7 R8 R9 R10 R1 R2: every exponent with boundary fractions in all lanes
        for (int e = 0; e < 256; e++) begin
            for (int k = 0; k < 6; k++) begin
                sv = {mk(1'b1, 8'(e), fr[(k+3)%6]), mk(1'b0, 8'(e), fr[(k+2)%6]),
                      mk(1'b1, 8'(e), fr[(k+1)%6]), mk(k[0], 8'(e), fr[k])};
                run_op(e == 0 ? "R8/R9 R2" : (e == 255 ? "R10/R9 R2" : "R7 R2"),
                       2'b10, 4'hF, sv, pr);
                run_op("R1 R4", 2'b01, 4'hF, sv, pr);
                run_op("R1 R3", 2'b00, 4'(k), sv, ~pr);
            end
        end
        // R8 walking single bit subnormals
        for (int b = 0; b < 23; b++) begin
            sv = {4{mk(b[1], 8'd0, 23'(1) << b)}};
            run_op("R8", 2'b10, 4'hF, sv, pr);
        end
        // R11 signalling NaN and subnormal only in inactive lanes
        sv = {mk(0, 8'hFF, 23'h000005), mk(1, 8'h00, 23'h00_0010),
              mk(0, 8'h80, 23'h1), mk(1, 8'h7F, 23'h0)};
        run_op("R11", 2'b00, 4'hF, sv, pr);
        run_op("R11", 2'b01, 4'hF, sv, pr);
        run_op("R11", 2'b10, 4'hF, sv, pr);
        // R5 and R6: every specifier in every form
        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < 16; s++) begin
                sv = {mk(0, 8'hFF, 23'h1), mk(0, 8'h0, 23'h3), 64'h3F80_0000_C020_0000};
                run_op(f == 3 ? "R6" : (f == 0 ? "R3" : "R5"), 2'(f), 4'(s), sv,
                       {pr[127:0], 128'(s * 977 + f)});
            end
        end
        // R12 outputs hold while idle
        held = result;
        repeat (4) @(negedge clk);
        check("R12", {res_valid, result[254:0], 3'd0}, {1'b0, held[254:0], 3'd0});
        check("R12", {255'd0, result[255], 3'd0}, {255'd0, held[255], 3'd0});
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule